// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block is the arithmetic and logic stage of an 8-bit accumulator machine. It holds the accumulator byte and a five-flag status byte. Each cycle it gets an operation code and an operand byte. When the load strobe is high, the new accumulator value and the new flags are written on the rising clock edge. When the strobe is low, both registers keep their value.

The unit covers several groups of operations:
- binary add and subtract, each with or without the stored carry
- bitwise AND, OR and XOR, and compare
- increment and decrement
- four rotates, two of them through the carry
- complement of the accumulator, complement of the carry, and set carry
- decimal adjust for packed BCD, which uses the auxiliary (nibble) carry and the main carry

Each operation has its own rule for which flags it rewrites and which it keeps. Instruction fetch, decode and memory access belong to the surrounding core.

Top module: `acc_alu_unit`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and the flag byte to 0x00. Reset takes priority over the load strobe.
- R2: When `load_en` is low, the accumulator and the flags keep their values, whatever the operation code and operand are.
- R3: Flag byte layout:
  - bit 7 is sign, a copy of bit 7 of the result
  - bit 6 is zero, set when the 8-bit result is 0
  - bit 4 is the auxiliary (nibble) carry
  - bit 2 is parity, set when the result has an even number of 1 bits
  - bit 0 is carry
  - bits 5, 3 and 1 always read 0
- R4: Code 0 (add) writes acc+operand. Code 1 (add with carry) writes acc+operand+carry. Both rewrite all five flags. Carry is the carry out of bit 7, and the auxiliary carry is the carry out of bit 3.
- R5: Code 2 (subtract) writes acc−operand. Code 3 (subtract with borrow) writes acc−operand−carry. Both rewrite all five flags. Carry is set when a borrow out of bit 7 occurs, and the auxiliary carry is set when the low nibbles (with the borrow included) need a borrow.
- R6: Code 7 (compare) sets all five flags exactly as code 2 would, and leaves the accumulator unchanged.
- R7: Code 4 (AND), code 5 (XOR) and code 6 (OR) write the bitwise result and update sign, zero and parity from it. AND sets the auxiliary carry to 1 and clears carry. XOR and OR clear both.
- R8: Code 8 adds 1 and code 9 subtracts 1. Both update sign, zero, parity and the auxiliary carry (nibble carry for increment, nibble borrow for decrement), and leave carry unchanged.
- R9: Code 10 rotates left: bit 7 goes to bit 0 and to carry. Code 11 rotates right: bit 0 goes to bit 7 and to carry. All other flags stay unchanged.
- R10: Code 12 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Code 13 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7. All other flags stay unchanged.
- R11: Code 14 inverts the accumulator and changes no flag. Code 15 inverts only carry. Code 16 sets only carry. Codes 15 and 16 keep the accumulator.
- R12: Code 17 (decimal adjust) works in three steps:
  - If the low nibble exceeds 9 or the auxiliary carry is set, 6 is added, giving a 9-bit intermediate. The new auxiliary carry is 1 only when this step ran and the low nibble exceeded 9.
  - If bits 8..4 of that intermediate exceed 9 or carry is set, 0x60 is added.
  - The new carry is the old carry OR'd with that second step. Sign, zero and parity come from the final byte.
- R13: Codes 18 to 31 change neither the accumulator nor the flags, even when `load_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Commit strobe for the accumulator and the flags |
| op_code | input | 5 | Operation select (codes in R4 to R13) |
| operand | input | 8 | Second operand byte |
| acc_out | output | 8 | Registered accumulator |
| flags_out | output | 8 | Registered flag byte (layout in R3) |

## Verification
A wrong accumulator or flag bit shows on `acc_out` or `flags_out` one cycle after the committing edge. Because every operation reads the stored accumulator and carry, the error also spreads into every later result. The sweeps cover these cases:
- the flag-preserving operations (rotates, increment, decrement, complement), where a corrupted flag that should have been kept appears at once as a mismatch on an untouched bit
- decimal adjust with every combination of stored auxiliary carry and carry, where a bad nibble-carry path shows on the very next adjust
- the held cycles and the unused codes, where any spurious write is seen on the following cycle

// File: rtl/alu_pkg.sv
// Package: shared widths, operation codes and flag-byte helpers for the
// accumulator arithmetic unit. Assumes an 8-bit datapath with 4-bit nibbles.
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;

    // flag bit positions inside the status byte
    localparam int F_SIGN = 7;
    localparam int F_ZERO = 6;
    localparam int F_HALF = 4;
    localparam int F_PAR  = 2;
    localparam int F_CRY  = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
        OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
        OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
        OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
        OP_STC = 5'd16, OP_DAA = 5'd17
    } alu_op_e;

    // Build a full flag byte from a result plus the two carries.
    function automatic logic [DATA_W-1:0] make_flags(input logic [DATA_W-1:0] r,
                                                     input logic half,
                                                     input logic cry);
        logic [DATA_W-1:0] f;
        f         = '0;
        f[F_SIGN] = r[DATA_W-1];
        f[F_ZERO] = (r == '0);
        f[F_HALF] = half;
        f[F_PAR]  = ~(^r);
        f[F_CRY]  = cry;
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Module: adder/subtractor with carry-in, producing the byte result, the
// carry (or borrow) out of the top bit and the carry (or borrow) out of the
// low nibble. Purely combinational; assumes W is even.
module alu_addsub #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hout
);
    localparam int H = W / 2;

    logic [W:0] full;
    logic [H:0] half;

    // Sum or difference at full and nibble width; bit W / H is carry or borrow.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        end
    end

    assign res  = full[W-1:0];
    assign cout = full[W];
    assign hout = half[H];
endmodule

// File: rtl/alu_bitops.sv
// Module: bitwise logic, rotates and complement on the accumulator. Gives the
// selected result and the carry a rotate produces. Combinational; codes that
// are not bit operations give the accumulator unchanged and keep carry.
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cy,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res,
    output logic            rot_cy
);
    // Select the bit-level result and rotate carry for the current code.
    always_comb begin
        res    = a;
        rot_cy = cy;
        case (op)
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            OP_RLC: begin res = {a[W-2:0], a[W-1]}; rot_cy = a[W-1]; end
            OP_RRC: begin res = {a[0], a[W-1:1]};   rot_cy = a[0];   end
            OP_RAL: begin res = {a[W-2:0], cy};     rot_cy = a[W-1]; end
            OP_RAR: begin res = {cy, a[W-1:1]};     rot_cy = a[0];   end
            OP_CMA: res = ~a;
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_bcd_adj.sv
// Module: packed-BCD decimal adjust of the accumulator using the stored
// nibble carry and carry. Combinational; assumes an 8-bit byte of two digits.
module alu_bcd_adj #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         half_in,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         half_out,
    output logic         cy_out
);
    localparam int H = W / 2;
    localparam logic [H-1:0]  NIB_MAX = H'(9);
    localparam logic [H:0]    HI_MAX  = (H+1)'(9);
    localparam logic [W:0]    LO_FIX  = (W+1)'(6);
    localparam logic [W-1:0]  HI_FIX  = W'(8'h60);

    logic       lo_big;
    logic       lo_fix;
    logic       hi_fix;
    logic [W:0] step1;

    // Low-digit correction, then high-digit correction from the intermediate.
    always_comb begin
        lo_big   = (a[H-1:0] > NIB_MAX);
        lo_fix   = lo_big | half_in;
        step1    = {1'b0, a} + (lo_fix ? LO_FIX : '0);
        hi_fix   = (step1[W:H] > HI_MAX) | cy_in;
        res      = step1[W-1:0] + (hi_fix ? HI_FIX : '0);
        half_out = lo_fix & lo_big;
        cy_out   = cy_in | hi_fix;
    end
endmodule

// File: rtl/acc_alu_unit.sv
// Module: accumulator plus five-flag status register around the arithmetic,
// bit-operation and decimal-adjust units. A load strobe commits the new
// values; per-code rules decide which flags change. Sync active-low reset.
module acc_alu_unit
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] flags_out
);
    logic [DATA_W-1:0] acc_q, flags_q;
    logic [DATA_W-1:0] acc_d, flags_d;

    logic [DATA_W-1:0] as_b, as_res, bo_res, da_res;
    logic              as_cin, as_sub, as_cout, as_hout;
    logic              bo_cy, da_half, da_cy;
    logic              cy_now;

    assign cy_now = flags_q[F_CRY];

    // Choose adder operand, carry-in and direction for the arithmetic codes.
    always_comb begin
        as_b   = operand;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_code)
            OP_ADC:         as_cin = cy_now;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin as_sub = 1'b1; as_cin = cy_now; end
            OP_INC:         as_b = DATA_W'(1);
            OP_DEC: begin as_b = DATA_W'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a(acc_q), .b(as_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_cout), .hout(as_hout)
    );

    alu_bitops #(.W(DATA_W)) u_bitops (
        .a(acc_q), .b(operand), .cy(cy_now), .op(op_code),
        .res(bo_res), .rot_cy(bo_cy)
    );

    alu_bcd_adj #(.W(DATA_W)) u_bcd (
        .a(acc_q), .half_in(flags_q[F_HALF]), .cy_in(cy_now),
        .res(da_res), .half_out(da_half), .cy_out(da_cy)
    );

    // Pick the next accumulator and apply the per-code flag update rule.
    always_comb begin
        acc_d   = acc_q;
        flags_d = flags_q;
        case (op_code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                acc_d   = as_res;
                flags_d = make_flags(as_res, as_hout, as_cout);
            end
            OP_CMP: flags_d = make_flags(as_res, as_hout, as_cout);
            OP_INC, OP_DEC: begin
                acc_d   = as_res;
                flags_d = make_flags(as_res, as_hout, cy_now);
            end
            OP_AND: begin
                acc_d   = bo_res;
                flags_d = make_flags(bo_res, 1'b1, 1'b0);
            end
            OP_XOR, OP_OR: begin
                acc_d   = bo_res;
                flags_d = make_flags(bo_res, 1'b0, 1'b0);
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                acc_d          = bo_res;
                flags_d[F_CRY] = bo_cy;
            end
            OP_CMA: acc_d = bo_res;
            OP_CMC: flags_d[F_CRY] = ~cy_now;
            OP_STC: flags_d[F_CRY] = 1'b1;
            OP_DAA: begin
                acc_d   = da_res;
                flags_d = make_flags(da_res, da_half, da_cy);
            end
            default: ;
        endcase
    end

    // State registers: clear on reset, commit on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (load_en) begin
            acc_q   <= acc_d;
            flags_q <= flags_d;
        end
    end

    assign acc_out   = acc_q;
    assign flags_out = flags_q;

    // R2: no strobe, no change
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(acc_q) && $stable(flags_q)));

    // R3: zero flag agrees with the committed accumulator after an add
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && op_code == OP_ADD) |=> (flags_q[F_ZERO] == (acc_q == '0)));

    // R6: compare never writes the accumulator
    assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && op_code == OP_CMP) |=> $stable(acc_q));

    // R8: increment and decrement keep carry
    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (op_code == OP_INC || op_code == OP_DEC))
        |=> (flags_q[F_CRY] == $past(flags_q[F_CRY])));

    // R9: rotate left moves old bit 7 to carry, other flags kept
    assert_rotate_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && op_code == OP_RLC)
        |=> (flags_q[F_CRY] == $past(acc_q[DATA_W-1]) &&
             flags_q[DATA_W-1:1] == $past(flags_q[DATA_W-1:1])));

    // R11: complement inverts the accumulator and leaves flags alone
    assert_cma_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && op_code == OP_CMA)
        |=> (acc_q == ~$past(acc_q) && $stable(flags_q)));

    // R13: unused codes write nothing
    assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && op_code > OP_DAA) |=> ($stable(acc_q) && $stable(flags_q)));
endmodule

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc_out, flags_out;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_flg = 8'h00;

    acc_alu_unit dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .op_code(op_code),
        .operand(operand), .acc_out(acc_out), .flags_out(flags_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // flag byte per R3: S b7, Z b6, AC b4, P b2, CY b0
    function automatic logic [7:0] fl(input logic [7:0] r, input logic ac, input logic cy);
        return {r[7], (r == 8'h00), 1'b0, ac, 1'b0, ~(^r), 1'b0, cy};
    endfunction

    // reference behaviour from the requirements
    function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] f, input logic [7:0] b);
        int s, h;
        logic cy, ac, lo, hi;
        logic [7:0] r;
        cy = f[0]; ac = f[4];
        case (op)
            5'd0, 5'd1: begin
                s = int'(a) + int'(b) + ((op == 5'd1) ? int'(cy) : 0);
                h = int'(a[3:0]) + int'(b[3:0]) + ((op == 5'd1) ? int'(cy) : 0);
                r = s[7:0];
                return {r, fl(r, h > 15, s > 255)};
            end
            5'd2, 5'd3, 5'd7: begin
                s = int'(a) - int'(b) - ((op == 5'd3) ? int'(cy) : 0);
                h = int'(a[3:0]) - int'(b[3:0]) - ((op == 5'd3) ? int'(cy) : 0);
                r = s[7:0];
                return {(op == 5'd7) ? a : r, fl(r, h < 0, s < 0)};
            end
            5'd4: begin r = a & b; return {r, fl(r, 1'b1, 1'b0)}; end
            5'd5: begin r = a ^ b; return {r, fl(r, 1'b0, 1'b0)}; end
            5'd6: begin r = a | b; return {r, fl(r, 1'b0, 1'b0)}; end
            5'd8: begin r = a + 8'd1; return {r, fl(r, a[3:0] == 4'hF, cy)}; end
            5'd9: begin r = a - 8'd1; return {r, fl(r, a[3:0] == 4'h0, cy)}; end
            5'd10: return {{a[6:0], a[7]}, f[7:1], a[7]};
            5'd11: return {{a[0], a[7:1]}, f[7:1], a[0]};
            5'd12: return {{a[6:0], cy}, f[7:1], a[7]};
            5'd13: return {{cy, a[7:1]}, f[7:1], a[0]};
            5'd14: return {~a, f};
            5'd15: return {a, f[7:1], ~cy};
            5'd16: return {a, f[7:1], 1'b1};
            5'd17: begin
                lo = (a[3:0] > 4'd9) || ac;
                s  = int'(a) + (lo ? 6 : 0);
                hi = ((s >> 4) > 9) || cy;
                s  = s + (hi ? 96 : 0);
                r  = s[7:0];
                return {r, fl(r, lo && (int'(a[3:0]) + 6 > 15), cy | hi)};
            end
            default: return {a, f};
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1: return "R4";
            5'd2, 5'd3: return "R5";
            5'd7: return "R6";
            5'd4, 5'd5, 5'd6: return "R7";
            5'd8, 5'd9: return "R8";
            5'd10, 5'd11: return "R9";
            5'd12, 5'd13: return "R10";
            5'd14, 5'd15, 5'd16: return "R11";
            5'd17: return "R12";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [7:0] pick(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h0F;
            3: return 8'h80;
            4: return 8'h99;
            default: return 8'((i * 53 + 7) & 255);
        endcase
    endfunction

    task automatic check(input string req);
        n_vec++;
        if (acc_out !== m_acc || flags_out !== m_flg) begin
            n_bad++;
            $display("FAIL %s op=%0d opnd=%02h: acc=%02h flags=%02h, expected acc=%02h flags=%02h",
                     req, op_code, operand, acc_out, flags_out, m_acc, m_flg);
        end
    endtask

    // drive one cycle, then compare just after the committing edge
    task automatic apply(input logic [4:0] op, input logic [7:0] b, input logic ld, input string req);
        logic [15:0] nx;
        op_code = op; operand = b; load_en = ld;
        nx = model(op, m_acc, m_flg, b);
        @(posedge clk); #1;
        if (ld) begin m_acc = nx[15:8]; m_flg = nx[7:0]; end
        check(req);
        load_en = 1'b0;
    endtask

    task automatic set_state(input logic [7:0] a, input logic ac, input logic cy);
        apply(5'd4, 8'h00, 1'b1, "R7");
        apply(5'd6, a, 1'b1, "R7");
        if (ac) apply(5'd4, 8'hFF, 1'b1, "R7");
        if (cy) apply(5'd16, 8'h00, 1'b1, "R11");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset wins over an active strobe
        rst_n = 1'b0; load_en = 1'b1; op_code = 5'd0; operand = 8'h5A;
        repeat (3) @(posedge clk);
        #1; m_acc = 8'h00; m_flg = 8'h00; check("R1");
        rst_n = 1'b1; load_en = 1'b0;

        // R4 R5 R6 R7: binary codes over operand and carry patterns
        for (int ia = 0; ia < 24; ia++)
            for (int ib = 0; ib < 24; ib++)
                for (int c = 0; c < 2; c++)
                    for (int op = 0; op < 8; op++) begin
                        set_state(pick(ia), 1'b0, c[0]);
                        apply(5'(op), pick(ib), 1'b1, req_of(5'(op)));
                    end

        // R8 to R12: unary codes over every byte and every AC/CY pair
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 4; k++)
                for (int op = 8; op < 18; op++) begin
                    set_state(8'(a), k[1], k[0]);
                    apply(5'(op), 8'(a * 7), 1'b1, req_of(5'(op)));
                end

        // R2: strobe low with every code leaves state alone
        for (int i = 0; i < 64; i++) begin
            set_state(pick(i), i[0], i[1]);
            apply(5'(i % 32), pick(i + 3), 1'b0, "R2");
        end

        // R13: unused codes with the strobe high
        for (int i = 0; i < 56; i++) begin
            set_state(pick(i), i[0], i[1]);
            apply(5'(18 + (i % 14)), pick(i + 1), 1'b1, "R13");
        end

        // R3: flag byte patterns from known values
        set_state(8'h00, 1'b0, 1'b0);
        apply(5'd0, 8'h00, 1'b1, "R3");
        n_vec++;
        if (flags_out !== 8'h44) begin
            n_bad++;
            $display("FAIL R3: flags=%02h expected=44", flags_out);
        end

        // R1: mid-run reset clears a non-zero state
        set_state(8'hC3, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1; m_acc = 8'h00; m_flg = 8'h00;
        check("R1");

        finish_run();
    end
endmodule